// File: doc/BRIEF.md
# Serial Peripheral Master with Held Chip Select

This block is a register-programmed serial master that moves 8-bit characters over a four-wire serial link in mode 0. The clock idles low, data is launched while the clock is low, the peripheral's reply is sampled on each rising edge, and the most significant bit goes first. Software programs a clock divider, a lead delay and a trail delay. It then writes words into a transmit holding register. Each word carries a hold flag that decides whether chip select stays low once that word has finished.

The transmit path has two stages. A word moves from the holding register into the shifter as soon as a transfer can start, so the next word can be queued while the current one shifts. With the hold flag set and the next word already queued, characters run back to back at the normal bit rate. Each received character lands in a one-deep receive buffer. A single status read returns that byte together with an empty flag and a full flag. The sequencer has five named states:

- IDLE: chip select is at the programmed idle level.
- LEAD: chip select is asserted and the lead delay runs.
- SHIFT: the clock toggles and bits move.
- KEEP: chip select is held low with no clock, waiting for the next word.
- TRAIL: the trail delay runs before chip select is released.

Transitions:

- IDLE→LEAD when the block is enabled and a word is pending.
- LEAD→SHIFT when the lead count expires.
- SHIFT→SHIFT at a word end with the hold flag set and a word pending.
- SHIFT→KEEP at a word end with the hold flag set and nothing pending.
- SHIFT→TRAIL at a word end without the hold flag.
- KEEP→SHIFT when a word arrives.
- KEEP→TRAIL when the block is disabled.
- TRAIL→IDLE when the trail count expires.

A soft reset returns every state to IDLE.

Top module: `spi_cs_master`

## Requirements
- R1: After rst_n is released, cs_n is 1, sclk is 0, and a status read shows the receive-empty flag 1 and the transmit-full flag 0.
- R2: A read at address 5 returns the received byte in bits [7:0], the receive-empty flag in bit 8 and the transmit-full flag in bit 9. A completed character clears the empty flag. A status read sets it again unless a character completes in that same cycle.
- R3: A write to address 4 carries the character in bits [7:0] and the hold flag in bit 8. It is accepted only while the transmit-full flag is 0, and acceptance sets that flag. A write made while the flag is 1 is dropped.
- R4: sclk stays low whenever cs_n is high, mosi changes only while sclk is low, miso is sampled on the rising edge, and both directions are MSB first.
- R5: With P equal to the prescale field (address 1, bits [7:0]) and a value of 0 treated as 1, one sclk period lasts P+1 clock cycles. The low part of each period lasts floor((P+1)/2) cycles.
- R6: With S in address 2, bits [7:0], the first rising edge of sclk comes S+1+floor((P+1)/2) cycles after cs_n falls.
- R7: With T in address 2, bits [15:8], cs_n rises T+1 cycles after the last falling edge of sclk of a character whose hold flag is clear.
- R8: After a character with the hold flag set, cs_n stays low. The next character then shifts without a lead delay. When that next character is already queued, its clock continues at the regular bit period with no gap.
- R9: Bit 1 of address 0 is the enable. While it is 0, no transfer starts and a queued word stays pending.
- R10: Bit 0 of address 0 is a soft reset. One cycle after it is set, the sequencer is back in IDLE, the transmit-full flag is 0, the receive-empty flag is 1 and cs_n is at the idle level.
- R11: Bit 0 of address 3 is the level driven on cs_n when no transfer is in progress. Its reset value is 1.
- R12: The transmit-full flag clears when a word moves into the shifter, so a second word is accepted while the first is still shifting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of address 5 consumes the received byte |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
A word written at one edge raises the full flag after that edge. The sequencer takes the word at the next edge, so cs_n falls one cycle after the write. The bench counts falling clock edges from that point to predict the first sclk rise (S+1+floor((P+1)/2)), every following rise (P+1), and the release of cs_n (T+1 after the last fall). Because the bench samples every output at the falling edge of clk, each registered change is seen exactly once, in the cycle it is due. Status reads are sampled in the same cycle as the read strobe, because the read value is combinational. The empty flag is re-read one cycle later, after the read has taken effect.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_FMT  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_DLY  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_IDLE = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_TX   = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_KEEP  = 3'd3,
        ST_TRAIL = 3'd4
    } seq_state_e;
endpackage

// File: rtl/spi_cs_regs.sv
module spi_cs_regs
    import spi_cs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 8,
    parameter int DLY_W  = 8,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              enable,
    output logic              sw_rst,
    output logic [PRE_W-1:0]  presc,
    output logic [DLY_W-1:0]  setup_dly,
    output logic [DLY_W-1:0]  hold_dly,
    output logic              idle_lvl,
    output logic              tx_full,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_keep,
    output logic              rx_empty,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_byte
);
    logic [DATA_W-1:0] rx_data;
    logic              tx_wr;
    logic              stat_rd;

    assign tx_wr   = wr_en && (addr == ADR_TX) && !tx_full;
    assign stat_rd = rd_en && (addr == ADR_STAT);

    // configuration registers survive the soft reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable    <= 1'b0;
            sw_rst    <= 1'b0;
            presc     <= PRE_W'(3);
            setup_dly <= '0;
            hold_dly  <= '0;
            idle_lvl  <= 1'b1;
        end else if (wr_en) begin
            case (addr)
                ADR_CTRL: begin
                    sw_rst <= wdata[0];
                    enable <= wdata[1];
                end
                ADR_FMT:  presc <= wdata[PRE_W-1:0];
                ADR_DLY: begin
                    setup_dly <= wdata[DLY_W-1:0];
                    hold_dly  <= wdata[2*DLY_W-1:DLY_W];
                end
                ADR_IDLE: idle_lvl <= wdata[0];
                default: ;
            endcase
        end
    end

    // transmit holding register and receive buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_full  <= 1'b0;
            tx_data  <= '0;
            tx_keep  <= 1'b0;
            rx_empty <= 1'b1;
            rx_data  <= '0;
        end else if (sw_rst) begin
            tx_full  <= 1'b0;
            tx_keep  <= 1'b0;
            rx_empty <= 1'b1;
        end else begin
            if (tx_pop) begin
                tx_full <= 1'b0;
            end else if (tx_wr) begin
                tx_full <= 1'b1;
                tx_data <= wdata[DATA_W-1:0];
                tx_keep <= wdata[DATA_W];
            end
            if (rx_push) begin
                rx_data  <= rx_byte;
                rx_empty <= 1'b0;
            end else if (stat_rd) begin
                rx_empty <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL: rdata[1:0] = {enable, sw_rst};
            ADR_FMT:  rdata[PRE_W-1:0] = presc;
            ADR_DLY:  rdata[2*DLY_W-1:0] = {hold_dly, setup_dly};
            ADR_IDLE: rdata[0] = idle_lvl;
            ADR_STAT: begin
                rdata[DATA_W-1:0] = rx_data;
                rdata[DATA_W]     = rx_empty;
                rdata[DATA_W+1]   = tx_full;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
    import spi_cs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 8,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              enable,
    input  logic [PRE_W-1:0]  presc,
    input  logic [DLY_W-1:0]  setup_dly,
    input  logic [DLY_W-1:0]  hold_dly,
    input  logic              idle_lvl,
    input  logic              tx_full,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_keep,
    input  logic              miso,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              busy
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam int CNT_W = PRE_W + 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    seq_state_e        state, nstate;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  per_m1;
    logic [CNT_W-1:0]  half;
    logic [BIT_W-1:0]  bit_idx;
    logic [DLY_W-1:0]  dcnt;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic              keep_q;
    logic              start_ok;
    logic              at_half;
    logic              at_end;
    logic              word_end;

    assign per_m1   = (presc == '0) ? CNT_W'(1) : {1'b0, presc};
    assign half     = (per_m1 + CNT_W'(1)) >> 1;
    assign at_half  = (cnt == half);
    assign at_end   = (cnt == per_m1);
    assign word_end = (state == ST_SHIFT) && at_end && (bit_idx == LAST_BIT);
    assign start_ok = enable && tx_full;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= ST_IDLE;
        else if (sw_rst) state <= ST_IDLE;
        else             state <= nstate;
    end

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (start_ok) nstate = ST_LEAD;
            ST_LEAD:  if (dcnt >= setup_dly) nstate = ST_SHIFT;
            ST_SHIFT: begin
                if (word_end) begin
                    if (keep_q && start_ok) nstate = ST_SHIFT;
                    else if (keep_q)        nstate = ST_KEEP;
                    else                    nstate = ST_TRAIL;
                end
            end
            ST_KEEP: begin
                if (start_ok)     nstate = ST_SHIFT;
                else if (!enable) nstate = ST_TRAIL;
            end
            ST_TRAIL: if (dcnt >= hold_dly) nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_pop  = ((state == ST_IDLE) && start_ok) ||
                  ((state == ST_KEEP) && start_ok) ||
                  (word_end && keep_q && start_ok);
        rx_push = word_end;
        rx_byte = at_half ? {rx_sh[DATA_W-2:0], miso} : rx_sh;
        cs_n    = (state == ST_IDLE) ? idle_lvl : 1'b0;
        sclk    = (state == ST_SHIFT) && (cnt >= half);
        mosi    = tx_sh[DATA_W-1];
        busy    = (state != ST_IDLE);
    end

    // counters and shifters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            dcnt    <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            keep_q  <= 1'b0;
        end else if (sw_rst) begin
            cnt     <= '0;
            bit_idx <= '0;
            dcnt    <= '0;
            keep_q  <= 1'b0;
        end else begin
            if (nstate != state)                           dcnt <= '0;
            else if (state == ST_LEAD || state == ST_TRAIL) dcnt <= dcnt + DLY_W'(1);

            if (state != ST_SHIFT) cnt <= '0;
            else if (at_end)       cnt <= '0;
            else                   cnt <= cnt + CNT_W'(1);

            if (state != ST_SHIFT)            bit_idx <= '0;
            else if (at_end)                  bit_idx <= (bit_idx == LAST_BIT) ? '0 : bit_idx + BIT_W'(1);

            if (tx_pop) begin
                tx_sh  <= tx_data;
                keep_q <= tx_keep;
            end else if (state == ST_SHIFT && at_end && bit_idx != LAST_BIT) begin
                tx_sh  <= tx_sh << 1;
            end

            if (state == ST_SHIFT && at_half) rx_sh <= {rx_sh[DATA_W-2:0], miso};
        end
    end
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
    import spi_cs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 8,
    parameter int DLY_W  = 8,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    logic              enable_w, sw_rst_w, idle_lvl_w;
    logic [PRE_W-1:0]  presc_w;
    logic [DLY_W-1:0]  setup_w, hold_w;
    logic              tx_full_w, tx_keep_w, rx_empty_w;
    logic [DATA_W-1:0] tx_data_w, rx_byte_w;
    logic              tx_pop_w, rx_push_w, busy_w;

    spi_cs_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W), .DLY_W(DLY_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .enable(enable_w), .sw_rst(sw_rst_w),
        .presc(presc_w), .setup_dly(setup_w), .hold_dly(hold_w), .idle_lvl(idle_lvl_w),
        .tx_full(tx_full_w), .tx_data(tx_data_w), .tx_keep(tx_keep_w),
        .rx_empty(rx_empty_w), .tx_pop(tx_pop_w), .rx_push(rx_push_w), .rx_byte(rx_byte_w)
    );

    spi_cs_seq #(.DATA_W(DATA_W), .PRE_W(PRE_W), .DLY_W(DLY_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst_w), .enable(enable_w),
        .presc(presc_w), .setup_dly(setup_w), .hold_dly(hold_w), .idle_lvl(idle_lvl_w),
        .tx_full(tx_full_w), .tx_data(tx_data_w), .tx_keep(tx_keep_w), .miso(miso),
        .tx_pop(tx_pop_w), .rx_push(rx_push_w), .rx_byte(rx_byte_w),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy_w)
    );
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk
    import spi_cs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              mosi,
    input logic              cs_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              tx_full,
    input logic              rx_empty,
    input logic              rx_push,
    input logic              sw_rst,
    input logic              enable,
    input logic              busy
);
    assert_sclk_low_deselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_mosi_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_accept_sets_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_TX && !tx_full && !sw_rst) |=> tx_full);

    assert_rx_push_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !sw_rst) |=> !rx_empty);

    assert_soft_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (!tx_full && rx_empty && !busy));

    assert_no_start_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !enable) |=> !busy);
endmodule

bind spi_cs_master spi_cs_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .wr_en(wr_en), .addr(addr), .tx_full(tx_full_w), .rx_empty(rx_empty_w),
    .rx_push(rx_push_w), .sw_rst(sw_rst_w), .enable(enable_w), .busy(busy_w)
);

// File: tb/spi_cs_master_bench.sv
module spi_cs_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        sclk, mosi, miso, cs_n;

    int checks = 0;
    int failures = 0;

    logic [7:0]  s_byte = 8'h00;
    logic [2:0]  sbit = 3'd0;
    logic [15:0] mcap = 16'd0;
    int          mbits = 0;

    always #10 clk = ~clk;

    spi_cs_master u_spi_cs_master (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // peripheral model: drives MSB first, advances on falling sclk
    assign miso = s_byte[7 - sbit];
    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) sbit <= 3'd0;
        else      sbit <= sbit + 3'd1;
    end
    always @(posedge sclk) begin
        mcap  <= {mcap[14:0], mosi};
        mbits <= mbits + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_xfer(input string tag);
        int n = 0;
        while (cs_n && n < 2000) begin @(negedge clk); n++; end
        while (!cs_n && n < 4000) begin @(negedge clk); n++; end
        check({tag, " transfer finished"}, 32'(n < 4000), 32'd1);
    endtask

    task automatic t_reset;
        logic [15:0] st;
        check("R1 cs_n after reset", 32'(cs_n), 32'd1);
        check("R1 sclk after reset", 32'(sclk), 32'd0);
        reg_rd(3'd5, st);
        check("R1 rx_empty after reset", 32'(st[8]), 32'd1);
        check("R1 tx_full after reset", 32'(st[9]), 32'd0);
    endtask

    task automatic t_idle_level;
        reg_wr(3'd3, 16'h0000);
        check("R11 idle level 0 on cs_n", 32'(cs_n), 32'd0);
        reg_wr(3'd3, 16'h0001);
        check("R11 idle level 1 on cs_n", 32'(cs_n), 32'd1);
    endtask

    task automatic t_disabled;
        logic [15:0] st;
        int base;
        reg_wr(3'd1, 16'h0003);
        reg_wr(3'd2, 16'h0000);
        s_byte = 8'h96;
        base = mbits;
        reg_wr(3'd4, 16'h00A5);
        repeat (20) @(negedge clk);
        check("R9 no start while disabled", 32'(cs_n), 32'd1);
        reg_rd(3'd5, st);
        check("R9 word stays pending", 32'(st[9]), 32'd1);
        reg_wr(3'd4, 16'h003C);
        reg_wr(3'd0, 16'h0002);
        wait_xfer("R9");
        repeat (30) @(negedge clk);
        check("R3 write while full dropped (one char)", 32'(mbits - base), 32'd8);
        check("R4 mosi MSB first", 32'(mcap[7:0]), 32'hA5);
        reg_rd(3'd5, st);
        check("R4 received byte MSB first", 32'(st[7:0]), 32'h96);
        check("R2 rx_empty clear after char", 32'(st[8]), 32'd0);
        check("R3 tx_full clear after drop", 32'(st[9]), 32'd0);
        reg_rd(3'd5, st);
        check("R2 read consumes byte", 32'(st[8]), 32'd1);
    endtask

    task automatic t_timing;
        logic [15:0] st;
        int n, cyc, fall_at, rise_at;
        logic pv;
        reg_wr(3'd1, 16'h0004);
        reg_wr(3'd2, 16'h0203);
        s_byte = 8'hC3;
        reg_wr(3'd4, 16'h005A);
        n = 0;
        while (cs_n && n < 100) begin @(negedge clk); n++; end
        n = 0;
        while (!sclk && n < 100) begin @(negedge clk); n++; end
        check("R6 cs_n fall to first sclk rise", 32'(n), 32'd6);
        n = 0;
        while (sclk && n < 100) begin @(negedge clk); n++; end
        check("R5 sclk high part", 32'(n), 32'd3);
        while (!sclk && n < 100) begin @(negedge clk); n++; end
        check("R5 sclk period", 32'(n), 32'd5);
        cyc = 0; fall_at = -1; rise_at = -1; pv = sclk;
        while (rise_at < 0 && cyc < 500) begin
            @(negedge clk); cyc++;
            if (pv && !sclk) fall_at = cyc;
            if (cs_n) rise_at = cyc;
            pv = sclk;
        end
        check("R7 last fall to cs_n rise", 32'(rise_at - fall_at), 32'd3);
        check("R4 mosi pattern 5A", 32'(mcap[7:0]), 32'h5A);
        reg_rd(3'd5, st);
        check("R2 status byte C3", 32'(st[7:0]), 32'hC3);
    endtask

    task automatic t_keep_chain;
        logic [15:0] st;
        int base, rises, first, last, cyc, gap_bad;
        logic pv;
        reg_wr(3'd1, 16'h0000);
        reg_wr(3'd2, 16'h0004);
        s_byte = 8'h69;
        base = mbits;
        reg_wr(3'd4, 16'h0181);
        reg_wr(3'd4, 16'h007E);
        reg_rd(3'd5, st);
        check("R12 second word accepted while first active", 32'(st[9]), 32'd1);
        rises = 0; first = -1; last = -1; cyc = 0; gap_bad = 0; pv = sclk;
        while (!cs_n && cyc < 500) begin
            @(negedge clk); cyc++;
            if (!pv && sclk) begin
                if (last >= 0 && (cyc - last) != 2) gap_bad++;
                if (first < 0) first = cyc;
                last = cyc;
                rises++;
            end
            pv = sclk;
        end
        check("R8 sixteen rises under one select", 32'(rises), 32'd16);
        check("R8 R5 no gap at word boundary, period 2", 32'(gap_bad), 32'd0);
        check("R8 chained data", 32'(mcap), 32'h817E);
        check("R8 bit count", 32'(mbits - base), 32'd16);
        reg_rd(3'd5, st);
        check("R2 byte of second word", 32'(st[7:0]), 32'h69);
    endtask

    task automatic t_keep_wait;
        logic [15:0] st;
        int base;
        reg_wr(3'd1, 16'h0001);
        reg_wr(3'd2, 16'h0000);
        base = mbits;
        reg_wr(3'd4, 16'h01F0);
        repeat (40) @(negedge clk);
        check("R8 cs_n held after hold word", 32'(cs_n), 32'd0);
        reg_rd(3'd5, st);
        check("R8 holding register drained", 32'(st[9]), 32'd0);
        reg_wr(3'd4, 16'h000F);
        wait_xfer("R8");
        check("R8 two words under one select", 32'(mcap), 32'hF00F);
        check("R8 bits in held pair", 32'(mbits - base), 32'd16);
    endtask

    task automatic t_soft_reset;
        logic [15:0] st;
        int base;
        reg_wr(3'd1, 16'h0004);
        reg_wr(3'd2, 16'h0032);
        base = mbits;
        reg_wr(3'd4, 16'h0011);
        repeat (4) @(negedge clk);
        check("R10 select asserted before reset", 32'(cs_n), 32'd0);
        reg_wr(3'd0, 16'h0003);
        @(negedge clk);
        check("R10 cs_n back to idle", 32'(cs_n), 32'd1);
        reg_rd(3'd5, st);
        check("R10 tx_full cleared", 32'(st[9]), 32'd0);
        check("R10 rx_empty set", 32'(st[8]), 32'd1);
        reg_wr(3'd0, 16'h0002);
        repeat (80) @(negedge clk);
        check("R10 abandoned word never shifts", 32'(mbits - base), 32'd0);
        check("R10 stays idle", 32'(cs_n), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_level();
        t_disabled();
        t_timing();
        t_keep_chain();
        t_keep_wait();
        t_soft_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule